// File: doc/BRIEF.md
# Two-stage 4x4 packet switch network

This block connects four external input links to four external output links through two stages of 2x2 switches. Each switch keeps a small first-in first-out queue on each of its two inputs. A round-robin scheduler looks only at the packet at the front of each queue. A packet is an 8-bit identifier plus a 2-bit destination. The first stage steers on the upper destination bit and the second stage on the lower bit, so every packet leaves on the output whose index equals its destination.

Within one clock cycle the second stage decides first, because its outputs can always take a packet. It then tells the first stage which of its queues can take a packet in this cycle. A queue counts as able to take one if it has a free slot or if its front packet is leaving in this cycle. The first stage moves packets forward only into such queues. A packet that cannot move stays where it is. New external packets enter the first-stage queues last, once this cycle's departures are known. Packets are discarded only there, and each input keeps a count of its arrivals and its discards.

First-stage switch s feeds input s of both second-stage switches: its upper output feeds second-stage switch 0 and its lower output feeds second-stage switch 1. Queues update on one common clock edge.

Top module: `sw_net4`

## Requirements
- R1: While reset is asserted (active low, asynchronous), and in the cycle after it is released, no output is valid and every arrival and discard counter reads zero. Reset empties every queue and points every scheduler at its top input (input index 0 of that switch).
- R2: A packet presented with destination d leaves on output port d. Its identifier and destination are unchanged.
- R3: A packet offered at a clock edge to an empty network is valid at its output from the second following edge until the third.
- R4: Each output carries at most one packet per cycle. When two front packets in a switch want the same output, the input named by that switch's pointer wins. The pointer starts at the top input and alternates every cycle.
- R5: A second-stage queue refuses a packet only when it is full and its front packet is not leaving in that cycle. A first-stage packet that is refused, or that loses its output to the other input of its switch, stays at the front of its queue. No packet is lost inside the network.
- R6: An external arrival is stored when its first-stage queue has a free slot after this cycle's departure. Otherwise it is discarded. This includes a full queue whose front packet leaves in the same cycle, which still accepts. Discards happen only at the external inputs.
- R7: Each input's arrival counter (16 bits, input i at bits 16i+15..16i) rises by one for each cycle in which that input's valid bit is high. The discard counter for that input, in the same bit position, rises by one for each discarded arrival. When the valid bit is low, the identifier and destination inputs have no effect.
- R8: Packets that enter on the same input and share a destination leave in the order they arrived.
- Vector layout for R2 to R7: the port for input or output k uses identifier bits 8k+7..8k and destination bits 2k+1..2k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 4 | Arrival present on each external input |
| in_id_i | input | 32 | Packet identifier per input, 8 bits each |
| in_dst_i | input | 8 | Packet destination per input, 2 bits each |
| out_valid_o | output | 4 | Packet leaving on each external output |
| out_id_o | output | 32 | Identifier of the departing packet per output |
| out_dst_o | output | 8 | Destination of the departing packet per output |
| arr_cnt_o | output | 64 | Arrival counter per input, 16 bits each |
| drop_cnt_o | output | 64 | Discard counter per input, 16 bits each |

## Verification
The hard case is a second-stage queue that is full and drains its front packet in the same cycle that a first-stage switch pushes a new packet into it. The same overlap arises at a full first-stage queue that hands off its front packet while an external arrival comes in. Both are provoked by sustained traffic aimed at one or two outputs, which keeps every queue on the path full. Each such cycle is judged by comparing every output against a cycle-accurate queue model kept in the bench. Each input's discard counter is also compared with the model, so a missed hand-off shows up either as a wrong output or as an extra discard.

// File: rtl/sw_net4_pkg.sv
package sw_net4_pkg;
  localparam int DST_W = 2;
  localparam int NPORT = 4;

  typedef enum logic {
    SEL_TOP = 1'b0,
    SEL_BOT = 1'b1
  } sel_e;
endpackage

// File: rtl/sw_net4_fifo.sv
module sw_net4_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (pop_i)  rd_q <= nxt(rd_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o  = mem_q[rd_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
endmodule

// File: rtl/sw_net4_arb.sv
module sw_net4_arb
  import sw_net4_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] req_i,   // front packet present per input
  input  logic [1:0] port_i,  // wanted output per input
  input  logic [1:0] room_i,  // output can take a packet this cycle
  output logic [1:0] gnt_o,
  output logic       ptr_o
);
  sel_e ptr_q;
  logic hi, lo;

  assign hi = (ptr_q == SEL_BOT);
  assign lo = ~hi;

  always_comb begin
    gnt_o     = '0;
    gnt_o[hi] = req_i[hi] && room_i[port_i[hi]];
    gnt_o[lo] = req_i[lo] && room_i[port_i[lo]]
                && !(gnt_o[hi] && (port_i[hi] == port_i[lo]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= SEL_TOP;
    else         ptr_q <= (ptr_q == SEL_TOP) ? SEL_BOT : SEL_TOP;
  end

  assign ptr_o = hi;
endmodule

// File: rtl/sw_net4.sv
module sw_net4
  import sw_net4_pkg::*;
#(
  parameter int ID_W  = 8,
  parameter int DEPTH = 2,
  parameter int CNT_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NPORT-1:0]        in_valid_i,
  input  logic [NPORT*ID_W-1:0]   in_id_i,
  input  logic [NPORT*DST_W-1:0]  in_dst_i,
  output logic [NPORT-1:0]        out_valid_o,
  output logic [NPORT*ID_W-1:0]   out_id_o,
  output logic [NPORT*DST_W-1:0]  out_dst_o,
  output logic [NPORT*CNT_W-1:0]  arr_cnt_o,
  output logic [NPORT*CNT_W-1:0]  drop_cnt_o
);
  localparam int PKT_W = ID_W + DST_W;
  localparam int NSW   = NPORT / 2;

  logic [PKT_W-1:0] s0_head [NPORT];
  logic [PKT_W-1:0] s1_head [NPORT];
  logic [PKT_W-1:0] s1_din  [NPORT];
  logic [PKT_W-1:0] out_pkt [NPORT];
  logic [NPORT-1:0] s0_empty, s0_full, s0_pop, s0_push, drop;
  logic [NPORT-1:0] s1_empty, s1_full, s1_pop, s1_push, s1_avail;
  logic [2*NSW-1:0] sw_ptr;  // [NSW-1:0] first stage, upper half second stage

  // external inputs, first-stage queues, counters
  for (genvar i = 0; i < NPORT; i++) begin : g_in
    logic [CNT_W-1:0] arr_q, drop_q;

    assign s0_push[i] = in_valid_i[i] && (!s0_full[i] || s0_pop[i]);
    assign drop[i]    = in_valid_i[i] && s0_full[i] && !s0_pop[i];

    sw_net4_fifo #(.W(PKT_W), .DEPTH(DEPTH)) u_q0 (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .push_i (s0_push[i]),
      .data_i ({in_id_i[i*ID_W +: ID_W], in_dst_i[i*DST_W +: DST_W]}),
      .pop_i  (s0_pop[i]),
      .head_o (s0_head[i]),
      .empty_o(s0_empty[i]),
      .full_o (s0_full[i])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        arr_q  <= '0;
        drop_q <= '0;
      end else begin
        if (in_valid_i[i]) arr_q  <= arr_q + CNT_W'(1);
        if (drop[i])       drop_q <= drop_q + CNT_W'(1);
      end
    end

    assign arr_cnt_o [i*CNT_W +: CNT_W] = arr_q;
    assign drop_cnt_o[i*CNT_W +: CNT_W] = drop_q;
  end

  // first stage: route on destination MSB, gated by second-stage room
  for (genvar s = 0; s < NSW; s++) begin : g_s0
    sw_net4_arb u_arb (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .req_i (~s0_empty[2*s +: 2]),
      .port_i({s0_head[2*s+1][DST_W-1], s0_head[2*s][DST_W-1]}),
      .room_i({s1_avail[2+s], s1_avail[s]}),
      .gnt_o (s0_pop[2*s +: 2]),
      .ptr_o (sw_ptr[s])
    );

    for (genvar t = 0; t < NSW; t++) begin : g_link
      logic hit0, hit1;
      assign hit0 = s0_pop[2*s]   && (s0_head[2*s][DST_W-1]   == 1'(t));
      assign hit1 = s0_pop[2*s+1] && (s0_head[2*s+1][DST_W-1] == 1'(t));
      assign s1_push[2*t+s] = hit0 || hit1;
      assign s1_din[2*t+s]  = hit0 ? s0_head[2*s] : s0_head[2*s+1];
    end
  end

  // second stage: route on destination LSB, outputs always accept
  for (genvar t = 0; t < NSW; t++) begin : g_s1
    for (genvar s = 0; s < 2; s++) begin : g_q
      sw_net4_fifo #(.W(PKT_W), .DEPTH(DEPTH)) u_q1 (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .push_i (s1_push[2*t+s]),
        .data_i (s1_din[2*t+s]),
        .pop_i  (s1_pop[2*t+s]),
        .head_o (s1_head[2*t+s]),
        .empty_o(s1_empty[2*t+s]),
        .full_o (s1_full[2*t+s])
      );
      assign s1_avail[2*t+s] = !s1_full[2*t+s] || s1_pop[2*t+s];
    end

    sw_net4_arb u_arb (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .req_i (~s1_empty[2*t +: 2]),
      .port_i({s1_head[2*t+1][0], s1_head[2*t][0]}),
      .room_i(2'b11),
      .gnt_o (s1_pop[2*t +: 2]),
      .ptr_o (sw_ptr[NSW+t])
    );

    for (genvar o = 0; o < 2; o++) begin : g_out
      logic hit0, hit1;
      assign hit0 = s1_pop[2*t]   && (s1_head[2*t][0]   == 1'(o));
      assign hit1 = s1_pop[2*t+1] && (s1_head[2*t+1][0] == 1'(o));
      assign out_valid_o[2*t+o] = hit0 || hit1;
      assign out_pkt[2*t+o]     = hit0 ? s1_head[2*t] : (hit1 ? s1_head[2*t+1] : '0);
      assign out_id_o [(2*t+o)*ID_W +: ID_W]   = out_pkt[2*t+o][PKT_W-1:DST_W];
      assign out_dst_o[(2*t+o)*DST_W +: DST_W] = out_pkt[2*t+o][DST_W-1:0];
    end
  end
endmodule

// File: rtl/sw_net4_chk.sv
module sw_net4_chk #(
  parameter int CNT_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [3:0]         out_valid_i,
  input logic [7:0]         out_dst_i,
  input logic [4*CNT_W-1:0] arr_cnt_i,
  input logic [4*CNT_W-1:0] drop_cnt_i,
  input logic [3:0]         s1_push_i,
  input logic [3:0]         s1_pop_i,
  input logic [3:0]         s1_full_i,
  input logic [3:0]         ptr_i
);
  for (genvar k = 0; k < 4; k++) begin : g_k
    a_r2_dest_port: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_i[k] |-> (out_dst_i[2*k +: 2] == 2'(k)));

    a_r5_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (s1_push_i[k] && s1_full_i[k]) |-> s1_pop_i[k]);

    a_r4_ptr_alternates: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (ptr_i[k] != $past(ptr_i[k])));

    a_r6_drop_needs_arrival: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (drop_cnt_i[k*CNT_W +: CNT_W] != $past(drop_cnt_i[k*CNT_W +: CNT_W]))
      |-> (arr_cnt_i[k*CNT_W +: CNT_W] != $past(arr_cnt_i[k*CNT_W +: CNT_W])));

    a_r7_drop_le_arr: assert property (@(posedge clk_i) disable iff (!rst_ni)
      drop_cnt_i[k*CNT_W +: CNT_W] <= arr_cnt_i[k*CNT_W +: CNT_W]);
  end
endmodule

bind sw_net4 sw_net4_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .out_valid_i(out_valid_o),
  .out_dst_i  (out_dst_o),
  .arr_cnt_i  (arr_cnt_o),
  .drop_cnt_i (drop_cnt_o),
  .s1_push_i  (s1_push),
  .s1_pop_i   (s1_pop),
  .s1_full_i  (s1_full),
  .ptr_i      (sw_ptr)
);

// File: tb/sw_net4_bench.sv
module sw_net4_bench;
  localparam int DEPTH = 2;
  localparam int NV    = 20;
  // {valid[3:0], dst of input 3..0 (2 bits each, input i at [2i+1:2i])}
  localparam logic [11:0] STIM [NV] = '{
    12'hF_1B, 12'hF_E4, 12'h5_33, 12'hF_00, 12'hA_C6,
    12'hF_55, 12'h3_0F, 12'hF_AA, 12'hC_90, 12'hF_1E,
    12'h0_FF, 12'hF_27, 12'h9_81, 12'hF_FF, 12'h6_3C,
    12'hF_50, 12'hF_05, 12'h1_02, 12'hF_D8, 12'hE_6B
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  in_valid_i = '0;
  logic [31:0] in_id_i = '0;
  logic [7:0]  in_dst_i = '0;
  logic [3:0]  out_valid_o;
  logic [31:0] out_id_o;
  logic [7:0]  out_dst_o;
  logic [63:0] arr_cnt_o, drop_cnt_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] idc = '0;

  // queue model
  logic [9:0] mb0 [4][8];
  logic [9:0] mb1 [4][8];
  int         mc0 [4];
  int         mc1 [4];
  logic       mptr;
  int         m_arr [4];
  int         m_drop [4];
  logic [3:0] exp_v;
  logic [9:0] exp_p [4];

  always #4 clk_i = ~clk_i;

  sw_net4 #(.ID_W(8), .DEPTH(DEPTH), .CNT_W(16)) u_sw_net4 (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .in_valid_i(in_valid_i), .in_id_i(in_id_i), .in_dst_i(in_dst_i),
    .out_valid_o(out_valid_o), .out_id_o(out_id_o), .out_dst_o(out_dst_o),
    .arr_cnt_o(arr_cnt_o), .drop_cnt_o(drop_cnt_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 4; i++) begin
      mc0[i] = 0; mc1[i] = 0; m_arr[i] = 0; m_drop[i] = 0;
    end
    mptr = 1'b0;
  endtask

  task automatic model_cycle(input logic [3:0] v, input logic [31:0] ids, input logic [7:0] ds);
    logic [3:0] g1, g0, av;
    logic [1:0] rsv;
    logic [9:0] h;
    int fi, j, tg;
    g1 = '0; g0 = '0; exp_v = '0;
    for (int k = 0; k < 4; k++) exp_p[k] = '0;
    for (int t = 0; t < 2; t++) begin
      rsv = '0;
      for (int n = 0; n < 2; n++) begin
        j = (n == 0) ? int'(mptr) : int'(!mptr);
        fi = 2*t + j;
        if (mc1[fi] > 0) begin
          h = mb1[fi][0];
          if (!rsv[h[0]]) begin
            rsv[h[0]] = 1'b1; g1[fi] = 1'b1;
            exp_v[2*t + int'(h[0])] = 1'b1;
            exp_p[2*t + int'(h[0])] = h;
          end
        end
      end
    end
    for (int i = 0; i < 4; i++) av[i] = !(mc1[i] == DEPTH && !g1[i]);
    for (int s = 0; s < 2; s++) begin
      rsv = '0;
      for (int n = 0; n < 2; n++) begin
        j = (n == 0) ? int'(mptr) : int'(!mptr);
        fi = 2*s + j;
        if (mc0[fi] > 0) begin
          h = mb0[fi][0];
          if (!rsv[h[1]] && av[2*int'(h[1]) + s]) begin
            rsv[h[1]] = 1'b1; g0[fi] = 1'b1;
          end
        end
      end
    end
    for (int i = 0; i < 4; i++) if (g1[i]) begin
      for (int x = 0; x < 7; x++) mb1[i][x] = mb1[i][x+1];
      mc1[i]--;
    end
    for (int i = 0; i < 4; i++) if (g0[i]) begin
      h = mb0[i][0];
      for (int x = 0; x < 7; x++) mb0[i][x] = mb0[i][x+1];
      mc0[i]--;
      tg = 2*int'(h[1]) + i/2;
      mb1[tg][mc1[tg]] = h; mc1[tg]++;
    end
    for (int i = 0; i < 4; i++) if (v[i]) begin
      m_arr[i]++;
      if (mc0[i] < DEPTH) begin mb0[i][mc0[i]] = {ids[8*i +: 8], ds[2*i +: 2]}; mc0[i]++; end
      else m_drop[i]++;
    end
    mptr = !mptr;
  endtask

  // R2 R4 R5 R8: every output against the model, once per port per cycle
  task automatic compare_outputs();
    for (int k = 0; k < 4; k++) begin
      logic [10:0] act, exp;
      act = {out_valid_o[k], out_valid_o[k] ? {out_id_o[8*k +: 8], out_dst_o[2*k +: 2]} : 10'h0};
      exp = {exp_v[k], exp_p[k]};
      chk(act == exp, "R2_R4_R5_R8", $sformatf("output %0d", k), int'(act), int'(exp));
    end
  endtask

  task automatic run_ids(input logic [3:0] v, input logic [31:0] ids, input logic [7:0] ds);
    model_cycle(v, ids, ds);
    compare_outputs();
    in_valid_i = v; in_id_i = ids; in_dst_i = ds;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic run_cycle(input logic [3:0] v, input logic [7:0] ds);
    logic [31:0] ids;
    for (int i = 0; i < 4; i++) ids[8*i +: 8] = {idc[5:0], 2'(i)};
    idc++;
    run_ids(v, ids, ds);
  endtask

  task automatic do_reset();
    in_valid_i = '0;
    rst_ni = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    model_clear();
    rst_ni = 1'b1;
  endtask

  task automatic check_counters(input string tag);
    for (int i = 0; i < 4; i++) begin
      chk(arr_cnt_o[16*i +: 16] == 16'(m_arr[i]), tag, $sformatf("arrivals input %0d", i),
          int'(arr_cnt_o[16*i +: 16]), m_arr[i]);
      chk(drop_cnt_o[16*i +: 16] == 16'(m_drop[i]), tag, $sformatf("discards input %0d", i),
          int'(drop_cnt_o[16*i +: 16]), m_drop[i]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL R1 watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int sum;
    logic [63:0] arr_snap;
    model_clear();
    @(negedge clk_i);
    // R1: state while held in reset
    chk(out_valid_o == 4'h0, "R1", "valid in reset", int'(out_valid_o), 0);
    chk(arr_cnt_o == 64'h0 && drop_cnt_o == 64'h0, "R1", "counters in reset",
        int'(arr_cnt_o[15:0] | drop_cnt_o[15:0]), 0);
    do_reset();
    chk(out_valid_o == 4'h0, "R1", "valid after release", int'(out_valid_o), 0);

    // R3: single packet, input 0, destination 3
    run_ids(4'b0001, 32'h0000_00A5, 8'h03);
    run_cycle(4'b0000, 8'h00);
    chk(out_valid_o == 4'b1000 && out_id_o[31:24] == 8'hA5 && out_dst_o[7:6] == 2'd3,
        "R3", "second edge delivery", int'({out_valid_o, out_id_o[31:24]}), 'h8A5);
    run_cycle(4'b0000, 8'h00);
    chk(out_valid_o == 4'b0000, "R3", "single cycle on output", int'(out_valid_o), 0);

    // mixed traffic from the vector table, then drain
    for (int n = 0; n < NV; n++) run_cycle(STIM[n][11:8], STIM[n][7:0]);
    for (int n = 0; n < 8; n++) run_cycle(4'b0000, 8'h00);
    check_counters("R6_R7");

    // R7: valid low with noisy id/dst leaves counters and outputs alone
    arr_snap = arr_cnt_o;
    for (int n = 0; n < 3; n++) run_ids(4'b0000, 32'hFFFF_FFFF, 8'hFF);
    chk(arr_cnt_o == arr_snap, "R7", "arrivals unchanged while idle",
        int'(arr_cnt_o[15:0]), int'(arr_snap[15:0]));
    chk(out_valid_o == 4'h0, "R7", "no output from idle noise", int'(out_valid_o), 0);

    // R6: one steady stream never discards (full queue pops and accepts together)
    do_reset();
    for (int n = 0; n < 20; n++) run_cycle(4'b0001, 8'h00);
    chk(drop_cnt_o[15:0] == 16'd0, "R6", "steady stream discards", int'(drop_cnt_o[15:0]), 0);
    chk(out_valid_o[0] == 1'b1, "R6", "steady stream flowing", int'(out_valid_o[0]), 1);

    // R5 R6: hotspot, every input to output 0 keeps every queue full
    do_reset();
    for (int n = 0; n < 30; n++) run_cycle(4'b1111, 8'h00);
    chk(out_valid_o == 4'b0001, "R5", "hotspot output busy", int'(out_valid_o), 1);
    sum = 0;
    for (int i = 0; i < 4; i++) sum += int'(drop_cnt_o[16*i +: 16]);
    chk(sum > 0, "R6", "hotspot causes input discards", sum, 1);
    for (int n = 0; n < 20; n++) run_cycle(4'b0000, 8'h00);
    check_counters("R5_R6");

    // R4 R8: two hot outputs sharing second-stage switches
    do_reset();
    for (int n = 0; n < 16; n++) run_cycle(4'b1111, 8'b01_00_01_00);
    for (int n = 0; n < 16; n++) run_cycle(4'b0000, 8'h00);
    check_counters("R4_R8");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule